// File: doc/BRIEF.md
# Speculative Line State Array

This block holds the speculation state that sits beside a first-level data cache whose stores may run ahead of memory ordering. For every cache line it keeps a per-word valid mask. For every supported speculative sequence it keeps one read-tracking flag and one write-tracking flag per line. The data array and the tags live elsewhere. This block keeps only the state bits and produces the merge mask that a fill applies to the data array.

Retiring loads and stores mark the line with the sequence they belong to. A store places its word in the line, and marks that word valid, even while the line is still missing. A fill merges only the words that are not yet valid, and a permission fill reports which sequences wrote the line, so that their filled counters can advance. An invalidation or an eviction that reaches a line read by a sequence raises a violation. The violation names the oldest offending sequence, with age counted from a caller-supplied oldest pointer. A commit clears one sequence's flags on every line in one cycle. A rollback drops the data of every speculatively written line in one cycle.

Top module: `spec_line_state`

## Requirements
- R1: After reset every line has no valid words and no read or write flags, and no violation is reported.
- R2: A full-word store sets the valid bit of its word and the write flag of its sequence on that line. `st_first` is high in the store's cycle exactly when that sequence had not yet written the line.
- R3: A sub-word store (`st_sub`=1) to a line with no valid words raises `st_need_side` in its cycle and leaves the line's state unchanged. A sub-word store to a line with any valid word is written like a full-word store.
- R4: During a fill, `fill_mask` (bit k = word k) is the complement of the line's valid mask, so locally written words are preserved. After the fill, all words of the line are valid.
- R5: During a fill with `fill_perm`=1, `fill_credit` equals the line's write flags (bit s = sequence s). Without permission, `fill_credit` is zero.
- R6: A load sets the read flag of its sequence on its line.
- R7: An invalidation (`inv_evict`=0) to a line with any valid word raises `inv_rerequest` in the same cycle and clears all valid bits of the line. An invalidation to a line with no valid words, or any eviction, leaves `inv_rerequest` low.
- R8: In the cycle after an invalidation or eviction of a line that has read flags set, `viol_valid` is high and `viol_mask` holds those flags. `viol_seq` is the first set sequence found when counting upward, with wrap, from `oldest_seq`.
- R9: A commit clears the read and write flags of `commit_seq` on every line in one cycle and leaves the other sequences' flags alone.
- R10: A rollback clears all valid bits of every line that has any write flag, clears every write flag, and clears the read flags of the sequences in `rb_mask`. Lines with no write flag keep their valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Speculative load retires |
| ld_line | input | LW | Load line index |
| ld_seq | input | QW | Load sequence id |
| st_valid | input | 1 | Store retires |
| st_line | input | LW | Store line index |
| st_word | input | WW | Store word index |
| st_seq | input | QW | Store sequence id |
| st_sub | input | 1 | Store is narrower than a word |
| st_need_side | output | 1 | Sub-word store rejected, must be held outside |
| st_first | output | 1 | First write of this sequence to the line |
| fill_valid | input | 1 | Fill arrives |
| fill_line | input | LW | Fill line index |
| fill_perm | input | 1 | Fill carries write permission |
| fill_mask | output | WORDS | Words the fill may write |
| fill_credit | output | SEQS | Sequences whose filled counter advances |
| inv_valid | input | 1 | Invalidation or eviction |
| inv_line | input | LW | Target line |
| inv_evict | input | 1 | 1 = eviction, 0 = invalidation |
| inv_rerequest | output | 1 | Reissue permission and data request |
| oldest_seq | input | QW | Oldest active sequence id |
| viol_valid | output | 1 | Violation reported |
| viol_seq | output | QW | Oldest violating sequence |
| viol_mask | output | SEQS | All violating sequences |
| commit_valid | input | 1 | Bulk clear of one sequence |
| commit_seq | input | QW | Committing sequence |
| rb_valid | input | 1 | Rollback |
| rb_mask | input | SEQS | Discarded sequences |
| q_line | input | LW | Query line index |
| q_vld | output | WORDS | Query: valid mask |
| q_rd | output | SEQS | Query: read flags |
| q_wr | output | SEQS | Query: write flags |

## Verification
`st_need_side`, `st_first`, `fill_mask`, `fill_credit` and `inv_rerequest` are combinational. Each is due in the same cycle as its request. The bench drives requests on the falling edge and samples these outputs a nanosecond later. State changes land on the next rising edge. The bench reads them through the query port at the following falling edge, once the request inputs are idle. Violation reports are registered. They are due one rising edge after the invalidation and are sampled at the falling edge that follows it, before any other request is driven.

// File: rtl/spec_line_state.sv
module spec_line_state #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int SEQS  = 4,
  localparam int LW = $clog2(LINES),
  localparam int WW = $clog2(WORDS),
  localparam int QW = $clog2(SEQS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [LW-1:0]    ld_line,
  input  logic [QW-1:0]    ld_seq,
  input  logic             st_valid,
  input  logic [LW-1:0]    st_line,
  input  logic [WW-1:0]    st_word,
  input  logic [QW-1:0]    st_seq,
  input  logic             st_sub,
  output logic             st_need_side,
  output logic             st_first,
  input  logic             fill_valid,
  input  logic [LW-1:0]    fill_line,
  input  logic             fill_perm,
  output logic [WORDS-1:0] fill_mask,
  output logic [SEQS-1:0]  fill_credit,
  input  logic             inv_valid,
  input  logic [LW-1:0]    inv_line,
  input  logic             inv_evict,
  output logic             inv_rerequest,
  input  logic [QW-1:0]    oldest_seq,
  output logic             viol_valid,
  output logic [QW-1:0]    viol_seq,
  output logic [SEQS-1:0]  viol_mask,
  input  logic             commit_valid,
  input  logic [QW-1:0]    commit_seq,
  input  logic             rb_valid,
  input  logic [SEQS-1:0]  rb_mask,
  input  logic [LW-1:0]    q_line,
  output logic [WORDS-1:0] q_vld,
  output logic [SEQS-1:0]  q_rd,
  output logic [SEQS-1:0]  q_wr
);

  logic [WORDS-1:0] vld_q [LINES];
  logic [SEQS-1:0]  rd_q  [LINES];
  logic [SEQS-1:0]  wr_q  [LINES];
  logic [WORDS-1:0] vld_d [LINES];
  logic [SEQS-1:0]  rd_d  [LINES];
  logic [SEQS-1:0]  wr_d  [LINES];

  logic            st_ok;
  logic [SEQS-1:0] hit_rd;
  logic [QW-1:0]   pick;

  assign st_need_side  = st_valid && st_sub && (vld_q[st_line] == '0);
  assign st_ok         = st_valid && !st_need_side;
  assign st_first      = st_ok && !wr_q[st_line][st_seq];
  assign fill_mask     = fill_valid ? ~vld_q[fill_line] : '0;
  assign fill_credit   = (fill_valid && fill_perm) ? wr_q[fill_line] : '0;
  assign inv_rerequest = inv_valid && !inv_evict && (vld_q[inv_line] != '0);
  assign hit_rd        = inv_valid ? rd_q[inv_line] : '0;

  assign q_vld = vld_q[q_line];
  assign q_rd  = rd_q[q_line];
  assign q_wr  = wr_q[q_line];

  always_comb begin
    pick = '0;
    for (int k = SEQS - 1; k >= 0; k--) begin
      if (hit_rd[QW'((int'(oldest_seq) + k) % SEQS)])
        pick = QW'((int'(oldest_seq) + k) % SEQS);
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      vld_d[i] = vld_q[i];
      rd_d[i]  = rd_q[i];
      wr_d[i]  = wr_q[i];
      if (ld_valid && ld_line == LW'(i)) rd_d[i][ld_seq] = 1'b1;
      if (st_ok && st_line == LW'(i)) begin
        vld_d[i][st_word] = 1'b1;
        wr_d[i][st_seq]   = 1'b1;
      end
      if (fill_valid && fill_line == LW'(i)) vld_d[i] = '1;
      if (inv_valid && inv_line == LW'(i)) vld_d[i] = '0;
      if (commit_valid) begin
        rd_d[i][commit_seq] = 1'b0;
        wr_d[i][commit_seq] = 1'b0;
      end
      if (rb_valid) begin
        if (wr_q[i] != '0) vld_d[i] = '0;
        wr_d[i] = '0;
        rd_d[i] = rd_d[i] & ~rb_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= '0;
        rd_q[i]  <= '0;
        wr_q[i]  <= '0;
      end
      viol_valid <= 1'b0;
      viol_seq   <= '0;
      viol_mask  <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= vld_d[i];
        rd_q[i]  <= rd_d[i];
        wr_q[i]  <= wr_d[i];
      end
      viol_valid <= hit_rd != '0;
      viol_seq   <= pick;
      viol_mask  <= hit_rd;
    end
  end

  logic [SEQS-1:0] col_any;
  logic            wr_any;
  always_comb begin
    col_any = '0;
    wr_any  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      col_any = col_any | rd_q[i] | wr_q[i];
      wr_any  = wr_any | (wr_q[i] != '0);
    end
  end

  assert_viol_names_member_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> viol_mask[viol_seq]);

  assert_viol_follows_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && rd_q[inv_line] != '0) |=> viol_valid);

  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !ld_valid && !st_valid) |=> !col_any[$past(commit_seq)]);

  assert_rollback_no_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !st_valid) |=> !wr_any);

  assert_inv_drops_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_rerequest |=> vld_q[$past(inv_line)] == '0);

  assert_fill_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_valid && !rb_valid) |=> (&vld_q[$past(fill_line)]));

  assert_side_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_need_side && !fill_valid) |=> wr_q[$past(st_line)] == $past(wr_q[st_line]));

endmodule

// File: tb/spec_line_state_tb.sv
module spec_line_state_tb_top;
  localparam int LINES = 8, WORDS = 4, SEQS = 4;
  localparam int LW = 3, WW = 2, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ld_valid = 0, st_valid = 0, st_sub = 0, fill_valid = 0, fill_perm = 0;
  logic inv_valid = 0, inv_evict = 0, commit_valid = 0, rb_valid = 0;
  logic [LW-1:0] ld_line = 0, st_line = 0, fill_line = 0, inv_line = 0, q_line = 0;
  logic [WW-1:0] st_word = 0;
  logic [QW-1:0] ld_seq = 0, st_seq = 0, oldest_seq = 0, commit_seq = 0;
  logic [SEQS-1:0] rb_mask = 0;
  logic st_need_side, st_first, inv_rerequest, viol_valid;
  logic [WORDS-1:0] fill_mask, q_vld;
  logic [SEQS-1:0] fill_credit, viol_mask, q_rd, q_wr;
  logic [QW-1:0] viol_seq;

  spec_line_state #(.LINES(LINES), .WORDS(WORDS), .SEQS(SEQS)) dut_i (
    .clk, .rst_n, .ld_valid, .ld_line, .ld_seq, .st_valid, .st_line, .st_word,
    .st_seq, .st_sub, .st_need_side, .st_first, .fill_valid, .fill_line,
    .fill_perm, .fill_mask, .fill_credit, .inv_valid, .inv_line, .inv_evict,
    .inv_rerequest, .oldest_seq, .viol_valid, .viol_seq, .viol_mask,
    .commit_valid, .commit_seq, .rb_valid, .rb_mask, .q_line, .q_vld, .q_rd, .q_wr);

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 0; st_valid = 0; st_sub = 0; fill_valid = 0; fill_perm = 0;
    inv_valid = 0; inv_evict = 0; commit_valid = 0; rb_valid = 0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic line_is(input string req, input int ln, input int v, input int r, input int w);
    q_line = LW'(ln);
    #1;
    chk({req, " vld"}, q_vld, v);
    chk({req, " rd"}, q_rd, r);
    chk({req, " wr"}, q_wr, w);
  endtask

  task automatic store(input int ln, input int wd, input int sq, input bit sub,
                       output bit side, output bit first);
    st_valid = 1; st_line = LW'(ln); st_word = WW'(wd); st_seq = QW'(sq); st_sub = sub;
    #1; side = st_need_side; first = st_first;
    finish_op();
  endtask

  task automatic load(input int ln, input int sq);
    ld_valid = 1; ld_line = LW'(ln); ld_seq = QW'(sq);
    finish_op();
  endtask

  task automatic test_reset();
    for (int i = 0; i < LINES; i++) line_is("R1", i, 0, 0, 0);
    chk("R1 viol", viol_valid, 0);
  endtask

  task automatic test_store();
    bit s, f;
    store(2, 1, 0, 0, s, f);
    chk("R2 first", f, 1);
    chk("R2 side", s, 0);
    line_is("R2", 2, 4'b0010, 0, 4'b0001);
    store(2, 2, 0, 0, s, f);
    chk("R2 repeat first", f, 0);
    line_is("R2", 2, 4'b0110, 0, 4'b0001);
  endtask

  task automatic test_subword();
    bit s, f;
    store(3, 0, 1, 1, s, f);
    chk("R3 side", s, 1);
    chk("R3 first", f, 0);
    line_is("R3 rejected", 3, 0, 0, 0);
    store(2, 3, 0, 1, s, f);
    chk("R3 side valid line", s, 0);
    line_is("R3 accepted", 2, 4'b1110, 0, 4'b0001);
  endtask

  task automatic test_fill();
    fill_valid = 1; fill_line = 2; fill_perm = 1;
    #1;
    chk("R4 mask", fill_mask, 4'b0001);
    chk("R5 credit", fill_credit, 4'b0001);
    finish_op();
    line_is("R4 after", 2, 4'b1111, 0, 4'b0001);
    fill_valid = 1; fill_line = 5; fill_perm = 0;
    #1;
    chk("R4 mask empty line", fill_mask, 4'b1111);
    chk("R5 no perm", fill_credit, 0);
    finish_op();
  endtask

  task automatic test_load();
    load(5, 1);
    line_is("R6", 5, 4'b1111, 4'b0010, 0);
  endtask

  task automatic test_inval();
    bit s, f;
    inv_valid = 1; inv_line = 6;
    #1; chk("R7 empty", inv_rerequest, 0);
    finish_op();
    store(6, 0, 1, 0, s, f);
    inv_valid = 1; inv_line = 6;
    #1; chk("R7 rerequest", inv_rerequest, 1);
    finish_op();
    line_is("R7 cleared", 6, 0, 0, 4'b0010);
    chk("R7 no viol", viol_valid, 0);
  endtask

  task automatic test_viol();
    load(4, 1);
    load(4, 3);
    oldest_seq = 2;
    inv_valid = 1; inv_line = 4;
    finish_op();
    chk("R8 valid", viol_valid, 1);
    chk("R8 mask", viol_mask, 4'b1010);
    chk("R8 oldest wrap", viol_seq, 3);
    oldest_seq = 0;
    inv_valid = 1; inv_line = 4; inv_evict = 1;
    #1; chk("R7 evict", inv_rerequest, 0);
    finish_op();
    chk("R8 evict valid", viol_valid, 1);
    chk("R8 evict oldest", viol_seq, 1);
    @(negedge clk); #1;
    chk("R8 drop", viol_valid, 0);
  endtask

  task automatic test_commit();
    commit_valid = 1; commit_seq = 1;
    finish_op();
    line_is("R9 l5", 5, 4'b1111, 0, 0);
    line_is("R9 l4", 4, 0, 4'b1000, 0);
    line_is("R9 l6", 6, 0, 0, 0);
    line_is("R9 l2 kept", 2, 4'b1111, 0, 4'b0001);
  endtask

  task automatic test_rollback();
    bit s, f;
    store(7, 0, 2, 0, s, f);
    load(4, 2);
    rb_valid = 1; rb_mask = 4'b0100;
    finish_op();
    line_is("R10 l2", 2, 0, 0, 0);
    line_is("R10 l7", 7, 0, 0, 0);
    line_is("R10 l5 kept", 5, 4'b1111, 0, 0);
    line_is("R10 l4", 4, 0, 4'b1000, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    test_reset();
    test_store();
    test_subword();
    test_fill();
    test_load();
    test_inval();
    test_viol();
    test_commit();
    test_rollback();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule